// File: doc/BRIEF.md
# Atomic Compare-Swap and Test-Set Unit

This block carries out indivisible read-modify-write operations against a simple request/acknowledge memory port on behalf of a processor core. The core hands over an operation code, an operand size, one or two addresses and the compare and update register values. The unit reads the memory operand or operands, subtracts the compare value at the selected width to form condition flags, and writes back only if the comparison allows it. It then returns the condition flags and the compare-register values as they must be after the instruction.

Three operations are provided. Single compare-swap works on a byte, halfword or word. Dual compare-swap works on two halfword or word locations and updates them only when both comparisons are equal. Test-and-set works on one byte and always sets its top bit. A lock output stays high from the first read until the last write is acknowledged. If no write is needed, it falls as soon as that is decided. An external arbiter uses it to keep other masters off the memory for the whole sequence.

Operands travel right-aligned on the data buses. `mem_size` tells the memory which low bytes a write covers.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `mem_we` and `mem_lock` are low, and `res_flags` and both result registers are zero.
- R2: Single compare-swap (`req_op`=0), with the memory operand equal to the compare value at the chosen size (`req_size` 0=byte, 1=halfword, 2=word), makes one write of the update value to `req_addr0` with `mem_size` equal to the request size. The compare result is returned unchanged.
- R3: Single compare-swap with unequal operands makes no write. The result compare value is the compare register with its low bits, of the operand width, replaced by the memory operand. Its upper bits are kept.
- R4: `res_flags` is {N,Z,V,C} in bits 3..0, formed from memory operand minus compare value at the operand width. N is the result sign, Z is a zero result, V is signed overflow and C is the unsigned borrow.
- R5: Dual compare-swap (`req_op`=1) with both pairs equal writes the first update value to `req_addr0` and then the second update value to `req_addr1`. Both compare results are returned unchanged.
- R6: Dual compare-swap with either pair unequal makes no write, and both compare results take their memory operands. The flags come from the first pair when that pair differs, and otherwise from the second pair.
- R7: Test-and-set (`req_op`=2) always operates on a byte, whatever `req_size` is. Its flags are N = bit 7 and Z = byte is zero, with V and C cleared. It always writes the byte back with bit 7 forced to one.
- R8: `mem_lock` is high on every cycle with `mem_req` high, and it stays high continuously from the first read through the last write acknowledge. When no write follows, it drops in the cycle after the operands are evaluated. A skipped write holds the lock for 3 cycles (single) or 5 cycles (dual) with a one-cycle acknowledge latency, and a completed write holds it for 5 or 9 cycles.
- R9: A request with a reserved op code (3), a reserved size (3), or a dual compare-swap at byte size is ignored. No memory request is made, and `busy` and `done` stay low.
- R10: `done` pulses for one cycle when the operation ends, and the results hold their values until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start pulse, sampled only while idle |
| req_op | input | 2 | 0 single compare-swap, 1 dual compare-swap, 2 test-and-set |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr0 | input | AW | First operand address |
| req_addr1 | input | AW | Second operand address (dual only) |
| req_cmp0 | input | DW | First compare register |
| req_cmp1 | input | DW | Second compare register |
| req_upd0 | input | DW | First update register |
| req_upd1 | input | DW | Second update register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_cmp0 | output | DW | First compare register after the operation |
| res_cmp1 | output | DW | Second compare register after the operation |
| res_flags | output | 4 | {N,Z,V,C} |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Bus lock for the arbiter |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Access size, same code as req_size |
| mem_wdata | output | DW | Right-aligned write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Right-aligned read data, valid with mem_ack |

## Verification
The hardest path to reach is a dual compare-swap where the first pair matches and the second does not. It must still skip both writes, take its flags from the second pair, and release the lock after two reads and no write. The stimulus sets up one memory word whose low half equals the compare register while its neighbour differs by a small amount. It also uses compare values whose upper bits differ from memory. This shows that only the operand width takes part in the comparison and in the reload. Lock duration is measured by counting lock cycles for each operation and comparing the count with the expected read/write count.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

   typedef enum logic [1:0] {
      OP_CAS  = 2'd0,
      OP_CAS2 = 2'd1,
      OP_TAS  = 2'd2
   } rmw_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } rmw_size_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD0,
      ST_RD1,
      ST_EVAL,
      ST_WR0,
      ST_WR1,
      ST_DONE
   } rmw_state_e;

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    size_mask = 32'h0000_00FF;
         2'd1:    size_mask = 32'h0000_FFFF;
         2'd2:    size_mask = 32'hFFFF_FFFF;
         default: size_mask = 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/rmw_sub_flags.sv
module rmw_sub_flags
   import atomic_rmw_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] minuend,
   input  logic [DW-1:0] subtrahend,
   input  logic [1:0]    size,
   output cc_t           cc
);

   logic [31:0] mask;
   logic [31:0] sa;
   logic [31:0] sb;
   logic [32:0] diff;
   logic [4:0]  msb;

   always_comb begin
      mask = size_mask(size);
      sa   = minuend[31:0] & mask;
      sb   = subtrahend[31:0] & mask;
      diff = {1'b0, sa} - {1'b0, sb};
      case (size)
         2'd0:    msb = 5'd7;
         2'd1:    msb = 5'd15;
         default: msb = 5'd31;
      endcase
      cc.n = diff[msb];
      cc.z = (diff[31:0] & mask) == 32'd0;
      cc.v = (sa[msb] != sb[msb]) && (diff[msb] != sa[msb]);
      cc.c = diff[32];
   end

   if (DW > 32) begin : g_upper_unused
      logic unused_upper;
      assign unused_upper = ^{minuend[DW-1:32], subtrahend[DW-1:32]};
   end

endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge
   import atomic_rmw_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] fresh,
   input  logic [1:0]    size,
   output logic [DW-1:0] merged
);

   logic [DW-1:0] mask_w;

   assign mask_w = DW'(size_mask(size));
   assign merged = (base & ~mask_w) | (fresh & mask_w);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import atomic_rmw_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [1:0]    req_size,
   input  logic [AW-1:0] req_addr0,
   input  logic [AW-1:0] req_addr1,
   input  logic [DW-1:0] req_cmp0,
   input  logic [DW-1:0] req_cmp1,
   input  logic [DW-1:0] req_upd0,
   input  logic [DW-1:0] req_upd1,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] res_cmp0,
   output logic [DW-1:0] res_cmp1,
   output logic [3:0]    res_flags,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_lock,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata
);

   localparam int LANES = 2;

   if (DW < 32) begin : g_bad_dw
      $error("atomic_rmw_unit: DW must be at least 32");
   end
   if (AW < 1) begin : g_bad_aw
      $error("atomic_rmw_unit: AW must be at least 1");
   end

   rmw_state_e    state;
   logic [1:0]    op_q;
   logic [1:0]    size_q;
   logic [AW-1:0] addr_q [LANES];
   logic [DW-1:0] cmp_q  [LANES];
   logic [DW-1:0] upd_q  [LANES];
   logic [DW-1:0] rd_q   [LANES];
   logic [DW-1:0] res_q  [LANES];
   logic [DW-1:0] merged [LANES];
   logic [DW-1:0] sub_b  [LANES];
   cc_t           lane_cc [LANES];
   cc_t           flags_q;
   cc_t           cc_sel;
   logic          is_tas;
   logic          is_dual;
   logic          legal;
   logic          do_write;
   logic [1:0]    eff_size;
   logic [DW-1:0] size_mask_w;

   assign is_tas   = (op_q == OP_TAS);
   assign is_dual  = (op_q == OP_CAS2);
   assign eff_size = is_tas ? SZ_BYTE : size_q;
   assign size_mask_w = DW'(size_mask(eff_size));

   always_comb begin
      case (req_op)
         OP_CAS:  legal = (req_size != 2'd3);
         OP_CAS2: legal = (req_size == SZ_HALF) || (req_size == SZ_WORD);
         OP_TAS:  legal = 1'b1;
         default: legal = 1'b0;
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_first
         assign sub_b[i] = is_tas ? '0 : cmp_q[i];
      end else begin : g_other
         assign sub_b[i] = cmp_q[i];
      end

      rmw_sub_flags #(.DW(DW)) i_flags (
         .minuend    (rd_q[i]),
         .subtrahend (sub_b[i]),
         .size       (eff_size),
         .cc         (lane_cc[i])
      );

      rmw_lane_merge #(.DW(DW)) i_merge (
         .base   (cmp_q[i]),
         .fresh  (rd_q[i]),
         .size   (eff_size),
         .merged (merged[i])
      );
   end

   always_comb begin
      cc_sel = lane_cc[0];
      if (is_dual && lane_cc[0].z) cc_sel = lane_cc[1];
   end

   always_comb begin
      case (op_q)
         OP_CAS:  do_write = lane_cc[0].z;
         OP_CAS2: do_write = lane_cc[0].z && lane_cc[1].z;
         default: do_write = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= '0;
         size_q  <= '0;
         flags_q <= '0;
         for (int i = 0; i < LANES; i++) begin
            addr_q[i] <= '0;
            cmp_q[i]  <= '0;
            upd_q[i]  <= '0;
            rd_q[i]   <= '0;
            res_q[i]  <= '0;
         end
      end else begin
         case (state)
            ST_IDLE: if (req_valid && legal) begin
               op_q      <= req_op;
               size_q    <= req_size;
               addr_q[0] <= req_addr0;
               addr_q[1] <= req_addr1;
               cmp_q[0]  <= req_cmp0;
               cmp_q[1]  <= req_cmp1;
               upd_q[0]  <= req_upd0;
               upd_q[1]  <= req_upd1;
               state     <= ST_RD0;
            end
            ST_RD0: if (mem_ack) begin
               rd_q[0] <= mem_rdata;
               state   <= is_dual ? ST_RD1 : ST_EVAL;
            end
            ST_RD1: if (mem_ack) begin
               rd_q[1] <= mem_rdata;
               state   <= ST_EVAL;
            end
            ST_EVAL: begin
               flags_q <= cc_sel;
               for (int i = 0; i < LANES; i++)
                  res_q[i] <= do_write ? cmp_q[i] : merged[i];
               state <= do_write ? ST_WR0 : ST_DONE;
            end
            ST_WR0: if (mem_ack) state <= is_dual ? ST_WR1 : ST_DONE;
            ST_WR1: if (mem_ack) state <= ST_DONE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state == ST_RD0) || (state == ST_RD1) ||
                  (state == ST_WR0) || (state == ST_WR1);
      mem_we    = (state == ST_WR0) || (state == ST_WR1);
      mem_lock  = mem_req || (state == ST_EVAL);
      mem_addr  = ((state == ST_RD1) || (state == ST_WR1)) ? addr_q[1] : addr_q[0];
      mem_size  = eff_size;
      mem_wdata = '0;
      if (state == ST_WR0)
         mem_wdata = is_tas ? DW'({rd_q[0][7:0] | 8'h80}) : (upd_q[0] & size_mask_w);
      else if (state == ST_WR1)
         mem_wdata = upd_q[1] & size_mask_w;
   end

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign res_cmp0  = res_q[0];
   assign res_cmp1  = res_q[1];
   assign res_flags = flags_q;

   // R8: no memory access outside the locked window
   p_req_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lock);

   // R8: a request is held steady until acknowledged
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R3: a skipped write releases the lock and finishes at once
   p_skip_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EVAL && !do_write) |=> (!mem_lock && done));

   // R7: test-and-set write data always has the top byte bit set
   p_tas_bit7_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && is_tas) |-> mem_wdata[7]);

   // R5: the second dual write follows the first to the second address
   p_dual_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR0 && mem_ack && is_dual) |=> (mem_we && mem_addr == addr_q[1]));

   // R9: illegal requests never start an operation
   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && !legal) |=> !busy);

endmodule

// File: tb/test_atomic_rmw_unit.sv
`timescale 1ns/1ps
module test_atomic_rmw_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [1:0]  req_size = '0;
   logic [15:0] req_addr0 = '0;
   logic [15:0] req_addr1 = '0;
   logic [31:0] req_cmp0 = '0;
   logic [31:0] req_cmp1 = '0;
   logic [31:0] req_upd0 = '0;
   logic [31:0] req_upd1 = '0;
   logic        busy, done, mem_req, mem_we, mem_lock;
   logic [31:0] res_cmp0, res_cmp1, mem_wdata;
   logic [3:0]  res_flags;
   logic [15:0] mem_addr;
   logic [1:0]  mem_size;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [16];
   int checks = 0;
   int errors = 0;
   int tot_wr = 0;
   int tot_req = 0;
   int tot_lock = 0;
   int lock_bad = 0;
   int done_seen = 0;
   logic [15:0] wr_addr_log [2];
   int cycles = 0;

   always #4 clk = ~clk;

   atomic_rmw_unit #(.DW(32), .AW(16)) i_atomic_rmw_unit (
      .clk, .rst_n, .req_valid, .req_op, .req_size,
      .req_addr0, .req_addr1, .req_cmp0, .req_cmp1, .req_upd0, .req_upd1,
      .busy, .done, .res_cmp0, .res_cmp1, .res_flags,
      .mem_req, .mem_we, .mem_lock, .mem_addr, .mem_size, .mem_wdata,
      .mem_ack, .mem_rdata
   );

   function automatic logic [31:0] tb_mask(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF :
             (sz == 2'd2) ? 32'hFFFF_FFFF : 32'h0;
   endfunction

   // memory model: acknowledge one cycle after a request appears
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we)
            mem[mem_addr[3:0]] <= (mem[mem_addr[3:0]] & ~tb_mask(mem_size)) |
                                  (mem_wdata & tb_mask(mem_size));
         else
            mem_rdata <= mem[mem_addr[3:0]] & tb_mask(mem_size);
      end else begin
         mem_ack <= 1'b0;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (mem_req && mem_we && !mem_ack) begin
         if (tot_wr % 2 == 0) wr_addr_log[0] = mem_addr; else wr_addr_log[1] = mem_addr;
         tot_wr++;
      end
      if (mem_req && !mem_ack) tot_req++;
      if (mem_lock) tot_lock++;
      if (mem_req && !mem_lock) lock_bad++;
      if (done) done_seen++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: expired actual=%0d expected<=100000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_cc(input logic [31:0] a, input logic [31:0] b, input int w);
      longint ua, ub, sa, sb, d, half;
      logic [63:0] du;
      half = 64'sd1 <<< (w - 1);
      ua = longint'(a) & ((64'sd1 <<< w) - 1);
      ub = longint'(b) & ((64'sd1 <<< w) - 1);
      sa = (ua >= half) ? ua - 2 * half : ua;
      sb = (ub >= half) ? ub - 2 * half : ub;
      d  = sa - sb;
      du = 64'(ua - ub);
      return {du[w-1], ua == ub, (d >= half) || (d < -half), ua < ub};
   endfunction

   int s_wr, s_lock, s_done, s_req;

   task automatic run_op(input logic [1:0] op, input logic [1:0] sz,
                         input logic [15:0] a0, input logic [15:0] a1,
                         input logic [31:0] c0, input logic [31:0] c1,
                         input logic [31:0] u0, input logic [31:0] u1);
      int t;
      @(negedge clk);
      s_wr = tot_wr; s_lock = tot_lock; s_done = done_seen; s_req = tot_req;
      req_op = op; req_size = sz; req_addr0 = a0; req_addr1 = a1;
      req_cmp0 = c0; req_cmp1 = c1; req_upd0 = u0; req_upd1 = u1;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!done && t < 100) begin
         @(negedge clk);
         t++;
      end
      chk("R10 done reached", {31'd0, done}, 32'd1);
   endtask

   task automatic t_reset();
      chk("R1 busy", {31'd0, busy}, 0);
      chk("R1 done", {31'd0, done}, 0);
      chk("R1 req/we/lock", {29'd0, mem_req, mem_we, mem_lock}, 0);
      chk("R1 flags", {28'd0, res_flags}, 0);
      chk("R1 res", res_cmp0 | res_cmp1, 0);
   endtask

   task automatic t_cas_word_equal();
      mem[1] = 32'h1234_5678;
      run_op(2'd0, 2'd2, 16'd1, 16'd0, 32'h1234_5678, 0, 32'hCAFE_F00D, 0);
      chk("R2 mem written", mem[1], 32'hCAFE_F00D);
      chk("R2 res unchanged", res_cmp0, 32'h1234_5678);
      chk("R4 flags eq", {28'd0, res_flags}, 32'h4);
      chk("R2 one write", tot_wr - s_wr, 1);
      chk("R8 lock cycles write", tot_lock - s_lock, 5);
      @(negedge clk);
      chk("R10 done one cycle", {31'd0, done}, 0);
      chk("R10 results held", res_cmp0, 32'h1234_5678);
   endtask

   task automatic t_cas_byte_unequal();
      mem[2] = 32'hAABB_CC80;
      run_op(2'd0, 2'd0, 16'd2, 16'd0, 32'hDEAD_BE01, 0, 32'h5555_5555, 0);
      chk("R3 mem unchanged", mem[2], 32'hAABB_CC80);
      chk("R3 res merge byte", res_cmp0, 32'hDEAD_BE80);
      chk("R4 byte overflow", {28'd0, res_flags}, {28'd0, exp_cc(32'h80, 32'h01, 8)});
      chk("R4 byte V expected", {28'd0, res_flags}, 32'h2);
      chk("R3 no write", tot_wr - s_wr, 0);
      chk("R8 lock cycles skip", tot_lock - s_lock, 3);
   endtask

   task automatic t_cas_half_borrow();
      mem[3] = 32'h0000_0001;
      run_op(2'd0, 2'd1, 16'd3, 16'd0, 32'h7777_0002, 0, 32'h0, 0);
      chk("R4 half borrow", {28'd0, res_flags}, {28'd0, exp_cc(32'h1, 32'h2, 16)});
      chk("R3 res merge half", res_cmp0, 32'h7777_0001);
      chk("R3 no write", tot_wr - s_wr, 0);
   endtask

   task automatic t_cas_half_equal();
      mem[3] = 32'h1111_2222;
      run_op(2'd0, 2'd1, 16'd3, 16'd0, 32'hFFFF_2222, 0, 32'h9999_ABCD, 0);
      chk("R2 half write only low", mem[3], 32'h1111_ABCD);
      chk("R4 half equal Z", {28'd0, res_flags}, 32'h4);
      chk("R2 res unchanged", res_cmp0, 32'hFFFF_2222);
   endtask

   task automatic t_dual_equal();
      mem[4] = 32'h8000_0000; mem[5] = 32'h7FFF_FFFF;
      run_op(2'd1, 2'd2, 16'd4, 16'd5, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1, 32'h2);
      chk("R5 first written", mem[4], 32'h1);
      chk("R5 second written", mem[5], 32'h2);
      chk("R5 two writes", tot_wr - s_wr, 2);
      chk("R5 write order", {wr_addr_log[0], wr_addr_log[1]}, {16'd4, 16'd5});
      chk("R5 res unchanged", res_cmp1, 32'h7FFF_FFFF);
      chk("R4 dual flags Z", {28'd0, res_flags}, 32'h4);
      chk("R8 lock cycles dual write", tot_lock - s_lock, 9);
   endtask

   task automatic t_dual_first_miss();
      mem[8] = 32'h10; mem[9] = 32'h20;
      run_op(2'd1, 2'd2, 16'd8, 16'd9, 32'h11, 32'h20, 32'hAAAA, 32'hBBBB);
      chk("R6 flags from first", {28'd0, res_flags}, {28'd0, exp_cc(32'h10, 32'h11, 32)});
      chk("R6 res0 loaded", res_cmp0, 32'h10);
      chk("R6 res1 loaded", res_cmp1, 32'h20);
      chk("R6 no write", tot_wr - s_wr, 0);
      chk("R6 mem kept", mem[8], 32'h10);
      chk("R8 lock cycles dual skip", tot_lock - s_lock, 5);
   endtask

   task automatic t_dual_second_miss();
      mem[6] = 32'h0000_1234; mem[7] = 32'h0000_5678;
      run_op(2'd1, 2'd1, 16'd6, 16'd7, 32'hAAAA_1234, 32'hBBBB_5670, 32'h1, 32'h2);
      chk("R6 flags from second", {28'd0, res_flags}, {28'd0, exp_cc(32'h5678, 32'h5670, 16)});
      chk("R6 res0 merged", res_cmp0, 32'hAAAA_1234);
      chk("R6 res1 merged", res_cmp1, 32'hBBBB_5678);
      chk("R6 no write", tot_wr - s_wr, 0);
      chk("R6 first mem kept", mem[6], 32'h0000_1234);
   endtask

   task automatic t_tas();
      mem[10] = 32'hFFFF_FF00;
      run_op(2'd2, 2'd2, 16'd10, 16'd0, 32'h0, 0, 32'h0, 0);
      chk("R7 zero byte set", mem[10], 32'hFFFF_FF80);
      chk("R7 zero flags", {28'd0, res_flags}, 32'h4);
      mem[11] = 32'h0000_0085;
      run_op(2'd2, 2'd1, 16'd11, 16'd0, 32'h1234, 0, 32'h0, 0);
      chk("R7 set byte flags", {28'd0, res_flags}, 32'h8);
      chk("R7 still written", tot_wr - s_wr, 1);
      chk("R7 byte kept", mem[11], 32'h0000_0085);
   endtask

   task automatic t_illegal(input logic [1:0] op, input logic [1:0] sz);
      int b = 0;
      @(negedge clk);
      s_req = tot_req; s_done = done_seen;
      req_op = op; req_size = sz; req_addr0 = 16'd12; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 6; k++) begin
         if (busy) b++;
         @(negedge clk);
      end
      chk("R9 no busy", b, 0);
      chk("R9 no request", tot_req - s_req, 0);
      chk("R9 no done", done_seen - s_done, 0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_cas_word_equal();
      t_cas_byte_unequal();
      t_cas_half_borrow();
      t_cas_half_equal();
      t_dual_equal();
      t_dual_first_miss();
      t_dual_second_miss();
      t_tas();
      t_illegal(2'd3, 2'd2);
      t_illegal(2'd0, 2'd3);
      t_illegal(2'd1, 2'd0);
      chk("R8 req never unlocked", lock_bad, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule